// File: doc/BRIEF.md
# Three-Level PWM Input Qualifier

This block sits in front of a half-bridge gate sequencer and turns a three-level PWM control input into a clean drive command. Two comparators outside the block classify the analog input. One flags that the level is above the upper threshold. The other flags that it is below the lower threshold. When neither flag is set, the input lies in a middle band that serves as a shutdown window. The comparator flags and a supply-good flag are asynchronous, so the block synchronizes all three before it uses them.

A high or low region loads a registered command, which drives exactly one of the two gate-enable outputs. A stay in the middle band does not change that command. If the stay lasts a full holdoff time, counted in clock cycles, both gate enables are forced low and a shutdown flag is raised. Shutdown stays in force while the input remains in the band. It clears in the same cycle that the command from the new region takes effect. While the supply-good flag is low, the block holds both gates off and reports shutdown.

Top module: `tsq_qualifier`

## Requirements
- R1: While reset is asserted and right after it, `shutdownOut` is 1 and `upperOn` and `lowerOn` are both 0.
- R2: The regions are encoded as follows. `cmpAboveHi`=1 is the high region, and this also applies when both flags are 1. `cmpAboveHi`=0 with `cmpBelowLo`=1 is the low region. Both flags 0 is the window. Outside shutdown, the high region gives `upperOn`=1, `lowerOn`=0, and the low region gives `lowerOn`=1, `upperOn`=0. A change of region shows at the outputs after the third rising clock edge.
- R3: A window stay shorter than `HOLD_CYCLES` synchronized cycles leaves the gate outputs unchanged. The last command is held.
- R4: A window stay of exactly `HOLD_CYCLES` synchronized cycles raises `shutdownOut`. It appears after rising edge 2+`HOLD_CYCLES`, counted from the first window sample.
- R5: While shutdown is active, both `upperOn` and `lowerOn` are 0, and they stay 0 for as long as the input remains in the window.
- R6: When the input leaves the window, shutdown clears in the same cycle that the command from the new region appears.
- R7: A low `supplyGood` forces `shutdownOut`=1 and both gates off, two rising edges after the change. Recovery follows two edges after `supplyGood` returns high.
- R8: `upperOn` and `lowerOn` are never 1 together.
- R9: Any non-window cycle restarts the holdoff timer. Two window stays, each shorter than the holdoff and separated by one non-window cycle, cause no shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmpAboveHi | input | 1 | Asynchronous flag: input is above the upper threshold |
| cmpBelowLo | input | 1 | Asynchronous flag: input is below the lower threshold |
| supplyGood | input | 1 | Asynchronous supply-good flag from an external hysteretic comparator |
| upperOn | output | 1 | Upper gate enable command |
| lowerOn | output | 1 | Lower gate enable command |
| shutdownOut | output | 1 | Both gates forced off (window holdoff expired, or supply not good) |

## Verification
The hardest cases to reach from the ports are the exact holdoff boundary and the timer restart. In both, one cycle of window time decides whether shutdown fires. The synchronizer delays every input by two edges. The stimulus therefore changes inputs only on falling edges and holds each region for an exact cycle count: one cycle short of the holdoff, exactly the holdoff, and two sub-holdoff stays split by a single-cycle gap. A cycle-level model built from the requirements predicts the expected outputs, which include the one-cycle shutdown pulse at the exact boundary.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  // Strobes passed from control to datapath once per cycle
  typedef struct packed {
    logic loadHigh;  // synchronized input sits in the high region
    logic loadLow;   // synchronized input sits in the low region
    logic gateOff;   // both gates must be held off
  } tsqStrobe_t;
endpackage

// File: rtl/tsq_sync.sv
module tsq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/tsq_ctrl.sv
module tsq_ctrl
  import tsq_pkg::*;
#(
  parameter int HOLD_CYCLES = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncAbove,
  input  logic       syncBelow,
  input  logic       powerOk,
  output logic       inWindow,
  output tsqStrobe_t strobe
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_VAL = CW'(HOLD_CYCLES);

  logic [CW-1:0] holdCnt;
  logic          holdDone;

  assign inWindow = ~syncAbove & ~syncBelow;
  assign holdDone = (holdCnt == HOLD_VAL);

  // Counts consecutive window samples; saturates; any exit restarts it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          holdCnt <= '0;
    else if (!inWindow) holdCnt <= '0;
    else if (!holdDone) holdCnt <= holdCnt + 1'b1;
  end

  always_comb begin
    strobe.loadHigh = syncAbove;
    strobe.loadLow  = syncBelow & ~syncAbove;
    strobe.gateOff  = ~powerOk | holdDone;
  end
endmodule

// File: rtl/tsq_datapath.sv
module tsq_datapath
  import tsq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  tsqStrobe_t strobe,
  output logic       cmdHigh,
  output logic       upperOn,
  output logic       lowerOn
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cmdHigh <= 1'b0;
    else if (strobe.loadHigh) cmdHigh <= 1'b1;
    else if (strobe.loadLow)  cmdHigh <= 1'b0;
  end

  assign upperOn = ~strobe.gateOff & cmdHigh;
  assign lowerOn = ~strobe.gateOff & ~cmdHigh;
endmodule

// File: rtl/tsq_qualifier.sv
module tsq_qualifier
  import tsq_pkg::*;
#(
  parameter int HOLD_CYCLES = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmpAboveHi,
  input  logic cmpBelowLo,
  input  logic supplyGood,
  output logic upperOn,
  output logic lowerOn,
  output logic shutdownOut
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] syncVec;
  logic            syncWin;
  logic            powerOk;
  logic            cmdHigh;
  tsqStrobe_t      strobe;

  tsq_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({supplyGood, cmpBelowLo, cmpAboveHi}),
    .syncOut(syncVec)
  );

  assign powerOk = syncVec[2];

  tsq_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .syncAbove(syncVec[0]), .syncBelow(syncVec[1]), .powerOk(powerOk),
    .inWindow(syncWin), .strobe(strobe)
  );

  tsq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdHigh(cmdHigh), .upperOn(upperOn), .lowerOn(lowerOn)
  );

  assign shutdownOut = strobe.gateOff;
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
  parameter int HOLD_CYCLES = 18
) (
  input logic clk,
  input logic rstN,
  input logic upperOn,
  input logic lowerOn,
  input logic shutdownOut,
  input logic syncWin,
  input logic powerOk,
  input logic cmdHigh
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  logic [CW-1:0] winRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       winRun <= '0;
    else if (!syncWin)               winRun <= '0;
    else if (winRun != CW'(HOLD_CYCLES)) winRun <= winRun + 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN) !(upperOn && lowerOn)); // R8
  AST_SHUT_GATES_OFF: assert property (@(posedge clk) disable iff (!rstN) shutdownOut |-> (!upperOn && !lowerOn)); // R5
  AST_CMD_HELD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN) syncWin |=> $stable(cmdHigh)); // R3
  AST_SHUT_AFTER_HOLDOFF: assert property (@(posedge clk) disable iff (!rstN) (powerOk && $past(powerOk) && $rose(shutdownOut)) |-> (winRun == CW'(HOLD_CYCLES))); // R4
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN) (powerOk && !syncWin) |=> (!shutdownOut || !powerOk)); // R6
  AST_SUPPLY_GATES: assert property (@(posedge clk) disable iff (!rstN) !powerOk |-> (shutdownOut && !upperOn && !lowerOn)); // R7
endmodule

bind tsq_qualifier tsq_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_checker (
  .clk(clk), .rstN(rstN), .upperOn(upperOn), .lowerOn(lowerOn),
  .shutdownOut(shutdownOut), .syncWin(syncWin), .powerOk(powerOk), .cmdHigh(cmdHigh)
);

// File: tb/tsq_qualifier_tb.sv
module tsq_qualifier_tb_top;
  localparam int HOLD = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmpAboveHi = 1'b0;
  logic cmpBelowLo = 1'b0;
  logic supplyGood = 1'b0;
  logic upperOn, lowerOn, shutdownOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  tsq_qualifier #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .cmpAboveHi(cmpAboveHi), .cmpBelowLo(cmpBelowLo),
    .supplyGood(supplyGood), .upperOn(upperOn), .lowerOn(lowerOn),
    .shutdownOut(shutdownOut)
  );

  // Requirement-level cycle model: two sync stages, window counter, command
  logic [2:0] m1 = '0, m2 = '0; // {supply, below, above}
  int  mCnt = 0;
  bit  mCmd = 1'b0;

  logic [2:0] expQ[$];  // {up, lo, shut}
  string      tagQ[$];

  task automatic step(input bit a, input bit b, input bit s, input string tag);
    bit win, sh;
    bit nCmd;
    nCmd = m2[0] ? 1'b1 : (m2[1] ? 1'b0 : mCmd);
    win  = !m2[0] && !m2[1];
    if (!win) mCnt = 0;
    else if (mCnt < HOLD) mCnt = mCnt + 1;
    mCmd = nCmd;
    m2 = m1;
    m1 = {s, b, a};
    sh = !m2[2] || (mCnt == HOLD);
    expQ.push_back({!sh && mCmd, !sh && !mCmd, sh});
    tagQ.push_back(tag);
  endtask

  // Driver: sets pins on a falling edge and queues the expected result
  task automatic drive(input bit a, input bit b, input bit s, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      cmpAboveHi = a; cmpBelowLo = b; supplyGood = s;
      step(a, b, s, tag);
      @(negedge clk);
    end
  endtask

  // Monitor: compares one queued item after every rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [2:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if ({upperOn, lowerOn, shutdownOut} !== e) begin
          errors++;
          $display("FAIL %s up/lo/shut actual %b%b%b expected %b%b%b at %0t",
                   t, upperOn, lowerOn, shutdownOut, e[2], e[1], e[0], $time);
        end
        checks++;
        if (upperOn && lowerOn) begin // R8
          errors++;
          $display("FAIL R8 both gates on actual 11 expected not 11 at %0t", $time);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++; // R1 during reset
    if ({upperOn, lowerOn, shutdownOut} !== 3'b001) begin
      errors++;
      $display("FAIL R1 reset actual %b%b%b expected 001", upperOn, lowerOn, shutdownOut);
    end
    @(negedge clk);
    rstN = 1'b1;
    drive(0, 0, 0, 3, "R1");
    // R2: supply comes up, alternate regions of various lengths
    drive(1, 0, 1, 8, "R2");
    drive(0, 1, 1, 8, "R2");
    drive(1, 0, 1, 1, "R2");
    drive(0, 1, 1, 2, "R2");
    drive(1, 0, 1, 6, "R2");
    drive(1, 1, 1, 5, "R2");   // both flags set counts as high
    drive(0, 1, 1, 6, "R2");
    // R3: excursion one cycle short of the holdoff
    drive(0, 0, 1, HOLD - 1, "R3");
    drive(0, 1, 1, 6, "R3");
    drive(1, 0, 1, 4, "R3");
    drive(0, 0, 1, HOLD - 1, "R3");
    drive(1, 0, 1, 6, "R3");
    // R9: restart after a single-cycle gap
    drive(0, 0, 1, HOLD - 4, "R9");
    drive(1, 0, 1, 1, "R9");
    drive(0, 0, 1, HOLD - 4, "R9");
    drive(0, 1, 1, 6, "R9");
    // R4: exactly the holdoff gives a one-cycle shutdown pulse
    drive(0, 0, 1, HOLD, "R4");
    drive(0, 1, 1, 6, "R4");
    // R5 and R6: long stays, then exit to each region
    drive(1, 0, 1, 4, "R5");
    drive(0, 0, 1, HOLD + 12, "R5");
    drive(1, 0, 1, 6, "R6");
    drive(0, 0, 1, HOLD + 8, "R5");
    drive(0, 1, 1, 6, "R6");
    // R7: supply drop and recovery, both regions
    drive(1, 0, 0, 6, "R7");
    drive(1, 0, 1, 6, "R7");
    drive(0, 1, 0, 3, "R7");
    drive(0, 1, 1, 6, "R7");
    drive(0, 0, 0, HOLD + 4, "R7");
    drive(1, 0, 1, 6, "R7");
    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule